// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the byte-level engine of a two-wire serial memory slave. A bus front end handles the line electrically and hands it single-cycle events: a START, a STOP, an SCL falling edge, and an SCL rising edge carrying the sampled SDA value. The engine turns these events into one output, an SDA pull-down enable. It also holds an 11-bit address pointer, reads a byte-wide memory that has one cycle of read latency, and passes each received write byte to a separate page-latch block.

The first byte after a START selects the device and the operation. Its three block-select bits become the top three address bits. In write mode the next byte sets the low eight address bits and the bytes after it are data for the page latch. In read mode the engine sends bytes from the pointer for as long as the master keeps acknowledging them. The page-latch block drives a busy input while it programs the array. While busy is high the engine acknowledges nothing, so a master can poll for completion.

Top module: `tws_slave_engine`

## Requirements
- R1: A control byte is acknowledged only when its top four bits are 1010. Bits 3..1 are block select and bit 0 is the direction (1 = read). On any other code SDA stays released and later bytes get no acknowledge until the next START.
- R2: A write-mode control byte followed by a word-address byte sets the pointer to {block select, word address}.
- R3: An acknowledge pulls SDA low from the SCL fall after the eighth bit until the SCL fall after the ninth bit.
- R4: While prog_busy is high, no byte is acknowledged, a valid control byte included, and no write is passed on.
- R5: Each acknowledged data byte in write mode gives a one-cycle wr_load pulse with the pointer address and the byte. A STOP after at least one data byte gives a one-cycle wr_commit pulse.
- R6: During a write the pointer advances only in its low four bits, wrapping inside the 16-byte page. A 17th data byte goes to the same address as the first.
- R7: A read-mode control byte leaves the pointer unchanged, so its block bits play no part. The byte read comes from the pointer, which holds the last accessed address plus one. Bits go out MSB first and SDA changes only after an SCL fall.
- R8: A repeated START after a word address keeps the pointer, and no wr_commit is produced.
- R9: A master acknowledge after a read byte starts the next sequential byte. A missing acknowledge leaves SDA released until START or STOP.
- R10: The read pointer advances by one per byte sent and wraps from 0x7FF to 0x000.
- R11: A START at any bit position restarts reception with a control byte.
- R12: After reset or a STOP, SDA is released and the engine is idle. A later START works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | START condition seen (one-cycle pulse) |
| ev_stop | input | 1 | STOP condition seen (one-cycle pulse) |
| ev_scl_fall | input | 1 | SCL falling edge (one-cycle pulse) |
| ev_bit_stb | input | 1 | SCL rising edge with a sampled bit (one-cycle pulse) |
| ev_bit_val | input | 1 | SDA level sampled at that rising edge |
| prog_busy | input | 1 | Array programming in progress |
| mem_rd_data | input | 8 | Read data for mem_rd_addr, one cycle late |
| sda_pull | output | 1 | Pull SDA low when 1 |
| mem_rd_addr | output | 11 | Read address (current pointer) |
| wr_load | output | 1 | Write byte valid for the page latch |
| wr_addr | output | 11 | Write byte address |
| wr_data | output | 8 | Write byte value |
| wr_commit | output | 1 | Start of the programming cycle at STOP |

## Verification
The master model drives a wired-AND line, so the engine's own acknowledge shows up in the bits it samples. Writes run as a single byte and as a 17-byte burst. The burst tells page-local wrap and overwrite apart from a linear increment. Reads run as a current-address read, a random read that crosses the top of the array, and a short sequential read. These tell pointer retention across a repeated START from full 11-bit wrap. Further patterns are a bad device code, a poll while busy, a START in mid-byte and a STOP in mid-read. They show that acknowledges are withheld and that the engine recovers at any bit position.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } tws_state_e;
endpackage

// File: rtl/tws_rx_shift.sv
module tws_rx_shift
  import tws_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       end_slot,
  input  logic                       bit_stb,
  input  logic                       bit_val,
  output logic [W-1:0]               byte_q,
  output logic [$clog2(W+1)-1:0]     cnt_q,
  output logic                       full
);
  localparam int CW = $clog2(W+1);

  logic [W-1:0]  byte_n;
  logic [CW-1:0] cnt_n;
  logic          shift_en;

  assign full     = (cnt_q == CW'(W));
  assign shift_en = bit_stb && !full;

  always_comb begin
    byte_n = byte_q;
    cnt_n  = cnt_q;
    if (clr || end_slot) begin
      cnt_n = '0;
    end else if (shift_en) begin
      byte_n = {byte_q[W-2:0], bit_val};
      cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      cnt_q  <= '0;
    end else begin
      byte_q <= byte_n;
      cnt_q  <= cnt_n;
    end
  end

  // R3: the bit count never runs past one byte, so the ninth clock is the ack slot
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(W));
endmodule

// File: rtl/tws_addr_ptr.sv
module tws_addr_ptr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              inc_page,
  input  logic              inc_lin,
  output logic [ADDR_W-1:0] ptr_q
);
  logic [ADDR_W-1:0] ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (ld)
      ptr_n = ld_val;
    else if (inc_page)
      ptr_n = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
    else if (inc_lin)
      ptr_n = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  // R6: a write step never leaves the current page
  p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page && !ld) |=> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]));

  // R10: a read step is a full-width increment that wraps at the top
  p_lin_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_lin && !ld && !inc_page) |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));
endmodule

// File: rtl/tws_tx_shift.sv
module tws_tx_shift
  import tws_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         drop,
  output logic         drive_low
);
  logic [W-1:0] sr_q, sr_n;
  logic         on_q, on_n;

  always_comb begin
    sr_n = sr_q;
    on_n = on_q;
    if (load) begin
      sr_n = load_val;
      on_n = 1'b1;
    end else if (drop) begin
      on_n = 1'b0;
    end else if (shift) begin
      sr_n = {sr_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      on_q <= 1'b0;
    end else begin
      sr_q <= sr_n;
      on_q <= on_n;
    end
  end

  assign drive_low = on_q & ~sr_q[W-1];

  // R9: once the byte ends the transmitter lets go of SDA
  p_tx_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !load) |=> !drive_low);
endmodule

// File: rtl/tws_slave_engine.sv
module tws_slave_engine
  import tws_pkg::*;
#(
  parameter int              ADDR_W   = 11,
  parameter int              BLK_W    = 3,
  parameter int              PAGE_W   = 4,
  parameter int              CODE_W   = 4,
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_scl_fall,
  input  logic              ev_bit_stb,
  input  logic              ev_bit_val,
  input  logic              prog_busy,
  input  logic [BYTE_W-1:0] mem_rd_data,
  output logic              sda_pull,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              wr_load,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  localparam int WORD_W = ADDR_W - BLK_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  tws_state_e        state_q, state_n;
  logic              ack_q, ack_n;
  logic              slot_q, slot_n;
  logic              have_q, have_n;
  logic              rdgo_q, rdgo_n;
  logic [BLK_W-1:0]  blk_q, blk_n;
  logic              wld_q, wld_n;
  logic              cmt_q, cmt_n;
  logic [ADDR_W-1:0] wadr_q;
  logic [BYTE_W-1:0] wdat_q;

  logic [BYTE_W-1:0] rx_byte;
  logic [CNT_W-1:0]  rx_cnt;
  logic              rx_full;
  logic              rx_end;
  logic [ADDR_W-1:0] ptr;
  logic              ptr_ld, inc_page, inc_lin;
  logic              tx_load, tx_shift, tx_drop, tx_low;
  logic              fall_full, fall_end, code_ok;

  tws_rx_shift #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(ev_start | ev_stop), .end_slot(rx_end),
    .bit_stb(ev_bit_stb), .bit_val(ev_bit_val),
    .byte_q(rx_byte), .cnt_q(rx_cnt), .full(rx_full)
  );

  tws_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld(ptr_ld), .ld_val({blk_q, rx_byte[WORD_W-1:0]}),
    .inc_page(inc_page), .inc_lin(inc_lin), .ptr_q(ptr)
  );

  tws_tx_shift #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(mem_rd_data),
    .shift(tx_shift), .drop(tx_drop), .drive_low(tx_low)
  );

  assign fall_full = ev_scl_fall && rx_full && !slot_q;
  assign fall_end  = ev_scl_fall && slot_q;
  assign code_ok   = (rx_byte[BYTE_W-1 -: CODE_W] == DEV_CODE);

  always_comb begin
    state_n  = state_q;
    ack_n    = ack_q;
    slot_n   = slot_q;
    have_n   = have_q;
    rdgo_n   = rdgo_q;
    blk_n    = blk_q;
    wld_n    = 1'b0;
    cmt_n    = 1'b0;
    ptr_ld   = 1'b0;
    inc_page = 1'b0;
    inc_lin  = 1'b0;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    tx_drop  = 1'b0;
    rx_end   = 1'b0;
    if (ev_start) begin
      state_n = ST_CTRL;
      ack_n   = 1'b0;
      slot_n  = 1'b0;
      have_n  = 1'b0;
      tx_drop = 1'b1;
    end else if (ev_stop) begin
      state_n = ST_IDLE;
      ack_n   = 1'b0;
      slot_n  = 1'b0;
      have_n  = 1'b0;
      tx_drop = 1'b1;
      cmt_n   = (state_q == ST_WDATA) && have_q && !prog_busy;
    end else if (fall_full) begin
      slot_n = 1'b1;
      unique case (state_q)
        ST_CTRL: begin
          if (code_ok && !prog_busy) begin
            ack_n   = 1'b1;
            blk_n   = rx_byte[BLK_W:1];
            rdgo_n  = 1'b1;
            state_n = rx_byte[0] ? ST_RDATA : ST_ADDR;
          end else begin
            state_n = ST_SKIP;
          end
        end
        ST_ADDR: begin
          if (!prog_busy) begin
            ack_n   = 1'b1;
            ptr_ld  = 1'b1;
            state_n = ST_WDATA;
          end else begin
            state_n = ST_SKIP;
          end
        end
        ST_WDATA: begin
          if (!prog_busy) begin
            ack_n    = 1'b1;
            wld_n    = 1'b1;
            inc_page = 1'b1;
            have_n   = 1'b1;
          end else begin
            state_n = ST_SKIP;
          end
        end
        ST_RDATA: tx_drop = 1'b1;
        default: ;
      endcase
    end else if (fall_end) begin
      slot_n = 1'b0;
      ack_n  = 1'b0;
      rx_end = 1'b1;
      if (state_q == ST_RDATA) begin
        if (rdgo_q) begin
          tx_load = 1'b1;
          inc_lin = 1'b1;
        end else begin
          state_n = ST_SKIP;
        end
      end
    end else if (ev_scl_fall) begin
      tx_shift = (state_q == ST_RDATA) && (rx_cnt != '0);
    end else if (ev_bit_stb && slot_q && state_q == ST_RDATA) begin
      rdgo_n = !ev_bit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      slot_q  <= 1'b0;
      have_q  <= 1'b0;
      rdgo_q  <= 1'b0;
      blk_q   <= '0;
      wld_q   <= 1'b0;
      cmt_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ack_q   <= ack_n;
      slot_q  <= slot_n;
      have_q  <= have_n;
      rdgo_q  <= rdgo_n;
      blk_q   <= blk_n;
      wld_q   <= wld_n;
      cmt_q   <= cmt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wadr_q <= '0;
      wdat_q <= '0;
    end else if (wld_n) begin
      wadr_q <= ptr;
      wdat_q <= rx_byte;
    end
  end

  assign sda_pull    = ack_q | tx_low;
  assign mem_rd_addr = ptr;
  assign wr_load     = wld_q;
  assign wr_addr     = wadr_q;
  assign wr_data     = wdat_q;
  assign wr_commit   = cmt_q;

  // R4: an acknowledge never starts while programming is busy
  p_busy_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> !$past(prog_busy));

  // R3: an acknowledge ends only on an SCL fall or a bus condition
  p_ack_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> $past(ev_scl_fall || ev_start || ev_stop));

  // R5: commit pulses only follow a STOP
  p_commit_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(ev_stop));

  // R5: no byte goes to the page latch while busy
  p_load_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |-> !$past(prog_busy));

  // R11: a START always leads to control-byte reception with SDA free
  p_start_ctrl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_start) |-> (state_q == ST_CTRL) && !sda_pull);

  // R12: a STOP releases SDA and idles the engine
  p_stop_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_stop && !ev_start) |-> (state_q == ST_IDLE) && !sda_pull);
endmodule

// File: tb/tb_tws_slave_engine.sv
module tb_tws_slave_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_start = 1'b0, ev_stop = 1'b0, ev_scl_fall = 1'b0;
  logic        ev_bit_stb = 1'b0, ev_bit_val = 1'b0, prog_busy = 1'b0;
  logic [7:0]  mem_rd_data;
  logic        sda_pull, wr_load, wr_commit;
  logic [10:0] mem_rd_addr, wr_addr;
  logic [7:0]  wr_data;

  logic [7:0]  mem [0:2047];
  logic [18:0] exp_q [$];
  int n_total = 0, n_bad = 0, n_commit = 0;
  bit done_flag = 1'b0;
  logic rel_first;   // sda_pull after the first fall of the last sent byte
  logic pull_ack;    // sda_pull during the ninth clock of the last sent byte

  always #5 clk = ~clk;

  tws_slave_engine dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_scl_fall(ev_scl_fall), .ev_bit_stb(ev_bit_stb), .ev_bit_val(ev_bit_val),
    .prog_busy(prog_busy), .mem_rd_data(mem_rd_data), .sda_pull(sda_pull),
    .mem_rd_addr(mem_rd_addr), .wr_load(wr_load), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit)
  );

  always_ff @(posedge clk) mem_rd_data <= mem[mem_rd_addr];

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 7) ^ (i >>> 3) ^ 8'h3C);
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // page-latch model and write scoreboard
  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = init_val(i);
    forever begin
      @(negedge clk);
      if (wr_load) begin
        n_total++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R5 unexpected write act=%0h exp=none", {wr_addr, wr_data});
        end else begin
          logic [18:0] e;
          e = exp_q.pop_front();
          if ({wr_addr, wr_data} !== e) begin
            n_bad++;
            $display("FAIL R5/R6 write act=%0h exp=%0h", {wr_addr, wr_data}, e);
          end
        end
        mem[wr_addr] = wr_data;
      end
      if (wr_commit) n_commit++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog act=running exp=finished");
    finish_run();
  end

  task automatic gap(); repeat (3) @(negedge clk); endtask
  task automatic do_fall(); ev_scl_fall = 1'b1; @(negedge clk); ev_scl_fall = 1'b0; gap(); endtask
  task automatic do_start(); ev_start = 1'b1; @(negedge clk); ev_start = 1'b0; gap(); endtask
  task automatic do_stop_raw(); ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0; gap(); endtask
  task automatic do_stop(); do_fall(); do_stop_raw(); endtask

  task automatic do_rise(input logic mb, output logic line);
    line = mb & ~sda_pull;
    ev_bit_val = line;
    ev_bit_stb = 1'b1;
    @(negedge clk);
    ev_bit_stb = 1'b0;
    gap();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic ln;
    for (int i = 7; i >= 0; i--) begin
      do_fall();
      if (i == 7) rel_first = sda_pull;
      do_rise(b[i], ln);
    end
    do_fall();
    pull_ack = sda_pull;
    do_rise(1'b1, ln);
    acked = (ln == 1'b0);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d, output bit stable);
    logic ln, p1;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      do_fall();
      p1 = sda_pull;
      do_rise(1'b1, ln);
      d[i] = ln;
      if (sda_pull !== p1) stable = 1'b0;
    end
    do_fall();
    if (sda_pull !== 1'b0) stable = 1'b0;
    do_rise(mack ? 1'b0 : 1'b1, ln);
  endtask

  task automatic expect_ack(input logic [7:0] b, input bit exp, input string req);
    logic a;
    send_byte(b, a);
    chk(a == exp, req, int'(a), int'(exp));
  endtask

  task automatic expect_read(input bit mack, input logic [7:0] exp, input string req);
    logic [7:0] d;
    bit st;
    read_byte(mack, d, st);
    chk(d == exp, req, int'(d), int'(exp));
    chk(st, {req, " sda held through high phase"}, int'(st), 1);
  endtask

  task automatic stop_check(input string req);
    do_fall();
    chk(sda_pull == 1'b0, req, int'(sda_pull), 0);
    do_stop_raw();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(sda_pull == 1'b0 && wr_load == 1'b0 && wr_commit == 1'b0, "R12 reset outputs",
        int'({sda_pull, wr_load, wr_commit}), 0);
    rst_n = 1'b1;
    gap();

    // byte write: ctrl blk 010, addr 0x35, data 0x5A
    do_start();
    expect_ack(8'hA4, 1'b1, "R1 control ack");
    chk(pull_ack == 1'b1, "R3 ack low in ninth clock", int'(pull_ack), 1);
    expect_ack(8'h35, 1'b1, "R2 word address ack");
    chk(rel_first == 1'b0, "R3 ack released after ninth clock", int'(rel_first), 0);
    exp_q.push_back({11'h235, 8'h5A});
    expect_ack(8'h5A, 1'b1, "R5 data ack");
    do_stop();
    chk(n_commit == 1, "R5 commit at stop", n_commit, 1);

    // busy: nothing acknowledged, nothing loaded or committed
    prog_busy = 1'b1;
    do_start();
    expect_ack(8'hA4, 1'b0, "R4 control ignored while busy");
    expect_ack(8'h35, 1'b0, "R4 later byte ignored while busy");
    do_stop();
    chk(n_commit == 1, "R4 no commit while busy", n_commit, 1);
    prog_busy = 1'b0;

    // current-address read with different block bits (pointer = 0x236)
    do_start();
    expect_ack(8'hA1, 1'b1, "R1 read control ack");
    expect_read(1'b0, init_val(11'h236), "R7 current address read");
    stop_check("R9 release after master nack");

    // wrong device code then an ignored byte
    do_start();
    expect_ack(8'h54, 1'b0, "R1 bad code not acked");
    expect_ack(8'hA0, 1'b0, "R1 bus ignored after bad code");
    do_stop();

    // random read at 0x7FE, sequential across the top
    do_start();
    expect_ack(8'hAE, 1'b1, "R2 control blk 7");
    expect_ack(8'hFE, 1'b1, "R2 word address FE");
    do_fall();
    do_start();
    expect_ack(8'hAF, 1'b1, "R8 read control after repeated start");
    expect_read(1'b1, init_val(11'h7FE), "R8 random read");
    expect_read(1'b1, init_val(11'h7FF), "R9 sequential read");
    expect_read(1'b0, init_val(0), "R10 pointer wrap to zero");
    stop_check("R9 release after last byte");
    chk(n_commit == 1, "R8 no commit from address-only write", n_commit, 1);

    // page write of 17 bytes from 0x11C
    do_start();
    expect_ack(8'hA2, 1'b1, "R1 control blk 1");
    expect_ack(8'h1C, 1'b1, "R2 word address 1C");
    for (int k = 0; k < 17; k++) begin
      exp_q.push_back({3'b001, 4'h1, 4'(4'hC + k), 8'(8'hC0 + k)});
      expect_ack(8'(8'hC0 + k), 1'b1, "R6 page data ack");
    end
    do_stop();
    chk(n_commit == 2, "R5 commit after page write", n_commit, 2);
    chk(exp_q.size() == 0, "R6 all page bytes loaded", exp_q.size(), 0);

    // pointer after page: 0x11D holds second byte
    do_start();
    expect_ack(8'hA1, 1'b1, "R7 read control");
    expect_read(1'b0, 8'hC1, "R6 pointer stays in page after write");
    do_stop();

    // 0x11C overwritten by the 17th byte
    do_start();
    expect_ack(8'hA2, 1'b1, "R2 control blk 1");
    expect_ack(8'h1C, 1'b1, "R2 word address 1C");
    do_fall();
    do_start();
    expect_ack(8'hA3, 1'b1, "R8 read control");
    expect_read(1'b1, 8'hD0, "R6 first page byte overwritten");
    expect_read(1'b0, 8'hC1, "R9 next sequential byte");
    do_stop();

    // START in mid byte
    do_start();
    for (int i = 0; i < 4; i++) begin
      logic ln;
      do_fall();
      do_rise(i[0] ? 1'b0 : 1'b1, ln);
    end
    do_start();
    expect_ack(8'hA1, 1'b1, "R11 control after mid-byte start");
    expect_read(1'b0, 8'hC2, "R11 read after restart");
    do_stop();

    // STOP in mid read, then a fresh transfer
    do_start();
    expect_ack(8'hA1, 1'b1, "R12 control before interrupted read");
    for (int i = 0; i < 3; i++) begin
      logic ln;
      do_fall();
      do_rise(1'b1, ln);
    end
    do_stop_raw();
    chk(sda_pull == 1'b0, "R12 sda released by stop", int'(sda_pull), 0);
    do_start();
    expect_ack(8'hA1, 1'b1, "R12 control after stop");
    expect_read(1'b0, init_val(11'h120), "R10 pointer advanced by interrupted read");
    do_stop();

    gap();
    finish_run();
  end
endmodule